// File: doc/BRIEF.md
# Byte-Lane Writable Data Memory

This block is the data store of a single-cycle load/store core. It holds a parameterised number of 32-bit words. The read port is combinational: whatever word the address points at appears on the output in the same cycle, with no clock in between. Writes happen on the rising clock edge. A store can be a byte, a halfword or a full word, and the block places sub-word stores into the right byte lanes of the addressed word while keeping the bytes around them.

The core does its own sub-word extraction and sign extension on loads, so the block always returns the whole aligned word. A 2-bit size code picks the store width, and one code value means "no write". The word index comes from the address bits just above the byte offset. Any address bits above the array depth are ignored, so addresses wrap within the array. The contents start at zero through simulation initialisation; there is no reset input.

Top module: `byte_lane_dmem`

## Requirements
- R1: Before any store, every word reads as 32'h0000_0000.
- R2: rd_data shows the word selected by the current addr in the same cycle, with no clock edge needed. A store's effect is visible right after the edge that performs it.
- R3: The contents change only at a rising clk edge with wr_en = 1. With wr_en = 0, no size code changes any word.
- R4: The word index is addr[IDX_W+1:2] with IDX_W = log2(DEPTH). Higher address bits are ignored, so addresses that differ only above bit IDX_W+1 reach the same word.
- R5: Size code 2'b10 (word) writes wr_data into all 32 bits of the addressed word, whatever addr[1:0] is.
- R6: Size code 2'b00 (byte) writes wr_data[7:0] into lane k = addr[1:0], which is bits [8k+7:8k]. The other three bytes keep their values, and wr_data[31:8] has no effect.
- R7: Size code 2'b01 (halfword) writes wr_data[15:0] into bits [15:0] when addr[1] = 0 and into bits [31:16] when addr[1] = 1. addr[0] is ignored, the other half keeps its value, and wr_data[31:16] has no effect.
- R8: Size code 2'b11 with wr_en = 1 changes no word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write clock, rising edge |
| wr_en | input | 1 | Store request for this cycle |
| wr_size | input | 2 | Store width: 00 byte, 01 halfword, 10 word, 11 none |
| addr | input | 32 | Byte address for both read and store |
| wr_data | input | 32 | Store value, taken from its low bits for sub-word stores |
| rd_data | output | 32 | Full aligned word at addr, combinational |

## Verification
The bench uses a 16-word array. It stores to every word at every byte offset with every size code, and after each store it compares the whole array against a model kept in the bench. This catches a design that writes the wrong lane, or that spills a byte or halfword into its neighbours. The store values carry junk in their upper bits, so a design that takes the byte or half from the wrong bits of wr_data shows up. The bench also checks that addr[0] is ignored for halfwords and addr[1:0] for words, which a design that shifts by the raw offset would get wrong. Stores with code 11, and stores with wr_en low, must leave the array untouched. Stores through aliased high addresses must land on the wrapped word, which a design that decodes too many index bits would miss. Reads are taken without any clock edge and right after a write edge, so a design with a registered read port would lag by one cycle.

// File: rtl/bldm_pkg.sv
package bldm_pkg;
  localparam int unsigned XLEN  = 32;
  localparam int unsigned LANES = XLEN / 8;
  localparam int unsigned OFF_W = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_NONE = 2'b11
  } st_size_e;
endpackage

// File: rtl/bldm_lane_sel.sv
module bldm_lane_sel
  import bldm_pkg::*;
(
  input  logic             wr_en,
  input  st_size_e         size,
  input  logic [OFF_W-1:0] off,
  output logic [LANES-1:0] strb
);
  always_comb begin
    strb = '0;
    if (wr_en) begin
      unique case (size)
        SZ_BYTE: strb[off] = 1'b1;
        SZ_HALF: strb = off[1] ? 4'b1100 : 4'b0011;
        SZ_WORD: strb = '1;
        default: strb = '0;
      endcase
    end
  end

  always_comb begin
    if (!$isunknown({wr_en, size, off})) begin
      a_r8_no_lane_when_idle: assert ((wr_en && size != SZ_NONE) || strb == '0);
      a_r6_byte_single_lane: assert (!(wr_en && size == SZ_BYTE) ||
                                     ($countones(strb) == 1 && strb[off]));
      a_r7_half_pair_aligned: assert (!(wr_en && size == SZ_HALF) ||
                                      ($countones(strb) == 2 && strb[{off[1], 1'b0}] &&
                                       strb[{off[1], 1'b1}]));
    end
  end
endmodule

// File: rtl/bldm_store_align.sv
module bldm_store_align
  import bldm_pkg::*;
(
  input  st_size_e        size,
  input  logic [XLEN-1:0] wr_data,
  output logic [XLEN-1:0] lane_data
);
  always_comb begin
    unique case (size)
      SZ_BYTE: lane_data = {LANES{wr_data[7:0]}};
      SZ_HALF: lane_data = {(LANES/2){wr_data[15:0]}};
      default: lane_data = wr_data;
    endcase
  end
endmodule

// File: rtl/bldm_word_array.sv
module bldm_word_array
  import bldm_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic [IDX_W-1:0] idx,
  input  logic [LANES-1:0] strb,
  input  logic [XLEN-1:0]  lane_data,
  output logic [XLEN-1:0]  rd_word
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] bank [DEPTH];

    initial begin
      for (int i = 0; i < DEPTH; i++) bank[i] = 8'h00;
    end

    always_ff @(posedge clk) begin
      if (strb[g]) bank[idx] <= lane_data[8*g +: 8];
    end

    assign rd_word[8*g +: 8] = bank[idx];
  end
endmodule

// File: rtl/byte_lane_dmem.sv
module byte_lane_dmem
  import bldm_pkg::*;
#(
  parameter int unsigned DEPTH = 1024
) (
  input  logic        clk,
  input  logic        wr_en,
  input  logic [1:0]  wr_size,
  input  logic [31:0] addr,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data
);
  localparam int unsigned IDX_W = $clog2(DEPTH);

  logic [IDX_W-1:0] index;
  logic [LANES-1:0] strb;
  logic [XLEN-1:0]  lane_data;
  st_size_e         size;
  logic             unused_addr_bits;

  assign size             = st_size_e'(wr_size);
  assign index            = addr[IDX_W+OFF_W-1:OFF_W];
  assign unused_addr_bits = ^addr[XLEN-1:IDX_W+OFF_W];

  bldm_lane_sel u_lane_sel (
    .wr_en (wr_en),
    .size  (size),
    .off   (addr[OFF_W-1:0]),
    .strb  (strb)
  );

  bldm_store_align u_align (
    .size      (size),
    .wr_data   (wr_data),
    .lane_data (lane_data)
  );

  bldm_word_array #(.DEPTH(DEPTH)) u_array (
    .clk       (clk),
    .idx       (index),
    .strb      (strb),
    .lane_data (lane_data),
    .rd_word   (rd_data)
  );

  // R5: a word store shows the full value on the next cycle if the index holds
  a_r5_word_lands: assert property (@(posedge clk)
    (!$isunknown({wr_en, wr_size, addr, wr_data}) && wr_en && wr_size == 2'b10)
    |=> (index != $past(index) || rd_data == $past(wr_data)));

  // R3: with no store at an edge, the word at a held index does not move
  a_r3_hold_without_write: assert property (@(posedge clk)
    (!$isunknown({wr_en, addr}) && !wr_en)
    |=> (index != $past(index) || $stable(rd_data)));
endmodule

// File: tb/byte_lane_dmem_bench.sv
`timescale 1ns/1ps
module byte_lane_dmem_bench;
  localparam int unsigned DEPTH = 16;

  logic        clk;
  logic        wr_en;
  logic [1:0]  wr_size;
  logic [31:0] addr;
  logic [31:0] wr_data;
  logic [31:0] rd_data;

  logic [31:0] model [DEPTH];
  int checks;
  int fails;
  bit done;

  byte_lane_dmem #(.DEPTH(DEPTH)) u_byte_lane_dmem (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_size (wr_size),
    .addr    (addr),
    .wr_data (wr_data),
    .rd_data (rd_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h (addr %h)", tag, got, exp, addr);
    end
  endtask

  task automatic rd(input logic [31:0] a, input string tag);
    addr = a;
    #0.2;
    check(tag, rd_data, model[a[5:2]]);
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < DEPTH; i++) rd(32'(i * 4), tag);
  endtask

  task automatic store(input logic [31:0] a, input logic [31:0] d,
                       input logic [1:0] sz, input logic en, input string tag);
    @(negedge clk);
    addr = a; wr_data = d; wr_size = sz; wr_en = en;
    @(posedge clk);
    #0.5;
    if (en) begin
      unique case (sz)
        2'b00: model[a[5:2]][a[1:0]*8 +: 8] = d[7:0];
        2'b01: if (a[1]) model[a[5:2]][31:16] = d[15:0];
               else      model[a[5:2]][15:0]  = d[15:0];
        2'b10: model[a[5:2]] = d;
        default: ;
      endcase
    end
    check({tag, " same-cycle R2"}, rd_data, model[a[5:2]]);
    wr_en = 1'b0;
    check_all(tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    checks = 0; fails = 0; done = 0;
    wr_en = 1'b0; wr_size = 2'b10; addr = '0; wr_data = '0;
    for (int i = 0; i < DEPTH; i++) model[i] = 32'h0;
    #1;
    for (int i = 0; i < DEPTH; i++) begin
      addr = 32'(i * 4); #0.2;
      check("R1 initial zero", rd_data, 32'h0);
    end

    // R5: word stores at every offset
    for (int i = 0; i < DEPTH; i++)
      store(32'(i * 4 + (i % 4)), 32'hA500_0000 ^ (32'(i) * 32'h0101_0101), 2'b10, 1'b1, "R5 word");

    // R6: byte stores to every lane, junk in upper bits
    for (int i = 0; i < DEPTH; i++)
      for (int o = 0; o < 4; o++)
        store(32'(i * 4 + o), 32'hDEAD_BE00 | 32'(i * 16 + o + 1), 2'b00, 1'b1, "R6 byte");

    // R7: halfword stores at every offset, addr[0] ignored
    for (int i = 0; i < DEPTH; i++)
      for (int o = 0; o < 4; o++)
        store(32'(i * 4 + o), 32'hCAFE_0000 | 32'(i * 256 + o * 17 + 3), 2'b01, 1'b1, "R7 half");

    // R8: code 11 with wr_en high writes nothing
    for (int i = 0; i < DEPTH; i++)
      store(32'(i * 4 + (i % 4)), 32'h1234_5678, 2'b11, 1'b1, "R8 no-write code");

    // R3: wr_en low with every size writes nothing
    for (int s = 0; s < 4; s++)
      for (int i = 0; i < DEPTH; i += 3)
        store(32'(i * 4 + s), 32'h8765_4321, 2'(s), 1'b0, "R3 disabled");

    // R4: high address bits ignored, wrap within array
    for (int i = 0; i < DEPTH; i++) begin
      store(32'hFFFF_FFC0 | 32'(i * 4), 32'h5A5A_0000 | 32'(i), 2'b10, 1'b1, "R4 alias word");
      rd(32'h0000_0C40 | 32'(i * 4), "R4 alias read");
    end
    store(32'h8000_0043, 32'hFFFF_FF77, 2'b00, 1'b1, "R4 alias byte");

    // R2: address changes with no clock edge
    @(negedge clk);
    for (int i = DEPTH - 1; i >= 0; i--) rd(32'(i * 4), "R2 comb read");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule